// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of one memory burst. A single-cycle start pulse captures a starting column, a burst length code and an ordering bit. From the next cycle on, the block emits one address per clock with a valid flag. On the final beat of a fixed-length burst it also raises a last-beat flag.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that holds the starting column. Only the low 1, 2 or 3 column bits change, and the upper bits keep the starting value. Sequential ordering steps the in-block offset up by one and wraps inside the block. Interleaved ordering XORs the starting offset with the beat index. A page-length burst counts upward from the starting column and wraps at the end of the page. It runs until the terminate input is asserted.

The block rejects a page-length burst with interleaved ordering. It raises an error flag for one cycle and emits no address. A new start that arrives while a burst is running replaces that burst on the next cycle. The page size is a parameter. It must be a multiple of 8, and every starting column must be below it.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `addrValid`, `lastBeat` and `modeError` are low. They stay low until a start pulse is sampled.
- R2: The cycle after a legal start pulse is sampled, `addrValid` is high and `colAddr` equals the captured start column.
- R3: In a fixed burst with `interleave`=0, beat k carries offset (start offset + k) mod N in the low log2(N) bits. The upper column bits equal those of the start column.
- R4: In a fixed burst with `interleave`=1, beat k carries offset (start offset XOR k) in the low log2(N) bits. The upper column bits are unchanged.
- R5: With no stop or restart, a fixed burst gives exactly N consecutive valid beats. `addrValid` is low in the following cycle.
- R6: `lastBeat` is high exactly on the Nth beat of a fixed burst. It is never high during a page-length burst.
- R7: A page-length burst gives start, start+1, ... modulo `PAGE_COLS`. It stays valid beyond `PAGE_COLS` beats until terminated.
- R8: If `terminate` is sampled high during a burst, and no start pulse is sampled in the same cycle, `addrValid` is low in the next cycle.
- R9: A start pulse with `lenCode`=3 and `interleave`=1 raises `modeError` for exactly the next cycle. It ends any active burst and produces no valid address.
- R10: A legal start pulse sampled during an active burst makes the next cycle carry beat 0 of the new burst.
- R11: `lenCode` encodes 0 as 2 beats, 1 as 4 beats, 2 as 8 beats and 3 as a page-length burst. `interleave`=1 selects interleaved ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begins a burst when sampled high |
| startCol | input | COL_W | Starting column |
| lenCode | input | 2 | Burst length code |
| interleave | input | 1 | 1 selects interleaved ordering |
| terminate | input | 1 | Stops the active burst |
| colAddr | output | COL_W | Column address of the current beat |
| addrValid | output | 1 | `colAddr` holds a burst beat |
| lastBeat | output | 1 | Final beat of a fixed burst |
| modeError | output | 1 | Unsupported page-length interleaved request |

## Verification
The bench builds the block with `PAGE_COLS` = 24. This is a page that is not a power of two, so the compare-and-clear wrap variant is elaborated. The small page lets the bench sweep every start column with every length code and both orderings. Page-length bursts run past the page end, so every start column exercises the wrap back to column 0. The error request is applied while a burst is running, and restarts are applied mid-burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  localparam logic [1:0] LEN_TWO  = 2'd0;
  localparam logic [1:0] LEN_FOUR = 2'd1;
  localparam logic [1:0] LEN_EIGHT = 2'd2;
  localparam logic [1:0] LEN_PAGE = 2'd3;

  // strobes from the sequencer to the address register
  typedef struct packed {
    logic       load;      // capture the start column
    logic       step;      // advance to the next beat
    logic       fullPage;  // page-length burst in progress
    logic       ilv;       // interleaved ordering
    logic [1:0] lenSel;    // length code of the running burst
    logic [2:0] nextBeat;  // index of the beat being produced next
  } dpCtl_t;

  function automatic logic [2:0] offsetMask(input logic [1:0] lenSel);
    case (lenSel)
      LEN_TWO:  offsetMask = 3'b001;
      LEN_FOUR: offsetMask = 3'b011;
      default:  offsetMask = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [1:0] lenCode,
  input  logic       interleave,
  input  logic       terminate,
  output dpCtl_t     ctl,
  output logic       addrValid,
  output logic       lastBeat,
  output logic       modeError
);

  logic       active;
  logic [2:0] beat;
  logic [1:0] lenReg;
  logic       ilvReg;
  logic       errReg;

  logic       illegalStart;
  logic       legalStart;
  logic       fullReg;
  logic [2:0] lastIdx;
  logic       atLast;

  always_comb begin
    illegalStart = startPulse && (lenCode == LEN_PAGE) && interleave;
    legalStart   = startPulse && !illegalStart;
    fullReg      = (lenReg == LEN_PAGE);
    lastIdx      = offsetMask(lenReg);
    atLast       = active && !fullReg && (beat == lastIdx);
  end

  always_comb begin
    ctl.load     = legalStart;
    ctl.step     = active && !startPulse && !terminate && !atLast;
    ctl.fullPage = fullReg;
    ctl.ilv      = ilvReg;
    ctl.lenSel   = lenReg;
    ctl.nextBeat = beat + 3'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      beat   <= '0;
      lenReg <= LEN_TWO;
      ilvReg <= 1'b0;
      errReg <= 1'b0;
    end else begin
      errReg <= illegalStart;
      if (legalStart) begin
        active <= 1'b1;
        beat   <= '0;
        lenReg <= lenCode;
        ilvReg <= interleave;
      end else if (illegalStart) begin
        active <= 1'b0;
      end else if (active) begin
        if (terminate || atLast) begin
          active <= 1'b0;
        end else begin
          beat <= beat + 3'd1;
        end
      end
    end
  end

  assign addrValid = active;
  assign lastBeat  = atLast;
  assign modeError = errReg;

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int PAGE_COLS = 512,
  parameter int COL_W     = $clog2(PAGE_COLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colAddr
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_COLS - 1);
  localparam bit POW2_PAGE = ((PAGE_COLS & (PAGE_COLS - 1)) == 0);

  logic [COL_W-1:0] addrReg;
  logic [2:0]       startOff;

  logic [2:0]       mask;
  logic [2:0]       seqOff;
  logic [2:0]       ilvOff;
  logic [2:0]       newLow;
  logic [COL_W-1:0] fixedNext;
  logic [COL_W-1:0] pageNext;

  always_comb begin
    mask      = offsetMask(ctl.lenSel);
    seqOff    = (addrReg[2:0] + 3'd1) & mask;
    ilvOff    = (startOff ^ ctl.nextBeat) & mask;
    newLow    = (addrReg[2:0] & ~mask) | (ctl.ilv ? ilvOff : seqOff);
    fixedNext = {addrReg[COL_W-1:3], newLow};
  end

  generate
    if (POW2_PAGE) begin : g_wrapNatural
      assign pageNext = addrReg + COL_W'(1);
    end else begin : g_wrapCompare
      assign pageNext = (addrReg == LAST_COL) ? '0 : addrReg + COL_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      startOff <= '0;
    end else if (ctl.load) begin
      addrReg  <= startCol;
      startOff <= startCol[2:0];
    end else if (ctl.step) begin
      addrReg  <= ctl.fullPage ? pageNext : fixedNext;
    end
  end

  assign colAddr = addrReg;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int PAGE_COLS = 512,
  parameter int COL_W     = $clog2(PAGE_COLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       lenCode,
  input  logic             interleave,
  input  logic             terminate,
  output logic [COL_W-1:0] colAddr,
  output logic             addrValid,
  output logic             lastBeat,
  output logic             modeError
);

  dpCtl_t ctl;

  burst_col_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .lenCode    (lenCode),
    .interleave (interleave),
    .terminate  (terminate),
    .ctl        (ctl),
    .addrValid  (addrValid),
    .lastBeat   (lastBeat),
    .modeError  (modeError)
  );

  burst_col_dp #(.PAGE_COLS(PAGE_COLS), .COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .startCol (startCol),
    .colAddr  (colAddr)
  );

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int PAGE_COLS = 512,
  parameter int COL_W     = $clog2(PAGE_COLS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [COL_W-1:0] startCol,
  input logic [1:0]       lenCode,
  input logic             interleave,
  input logic             terminate,
  input logic [COL_W-1:0] colAddr,
  input logic             addrValid,
  input logic             lastBeat,
  input logic             modeError
);

  logic badReq;
  assign badReq = startPulse && (lenCode == 2'd3) && interleave;

  assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !badReq) |=> (addrValid && colAddr == $past(startCol)));

  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startPulse) |=> !addrValid);

  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> addrValid);

  assert_page_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (int'(colAddr) < PAGE_COLS));

  assert_terminate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && terminate && !startPulse) |=> !addrValid);

  assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    badReq |=> (modeError && !addrValid));

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeError && !badReq) |=> !modeError);

endmodule

bind burst_col_gen burst_col_chk #(.PAGE_COLS(PAGE_COLS), .COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .startCol   (startCol),
  .lenCode    (lenCode),
  .interleave (interleave),
  .terminate  (terminate),
  .colAddr    (colAddr),
  .addrValid  (addrValid),
  .lastBeat   (lastBeat),
  .modeError  (modeError)
);

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;

  localparam int PAGE = 24;
  localparam int CW   = $clog2(PAGE);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [CW-1:0] startCol = '0;
  logic [1:0]    lenCode = 2'd0;
  logic          interleave = 1'b0;
  logic          terminate = 1'b0;
  logic [CW-1:0] colAddr;
  logic          addrValid;
  logic          lastBeat;
  logic          modeError;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_col_gen #(.PAGE_COLS(PAGE)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .terminate(terminate),
    .colAddr(colAddr), .addrValid(addrValid), .lastBeat(lastBeat),
    .modeError(modeError)
  );

  task automatic chk(input string req, input logic v, input int a,
                     input logic l, input logic e);
    vectors++;
    if (addrValid !== v || lastBeat !== l || modeError !== e ||
        (v && int'(colAddr) != a)) begin
      fails++;
      $display("FAIL %s: got v=%0b a=%0d l=%0b e=%0b exp v=%0b a=%0d l=%0b e=%0b",
               req, addrValid, colAddr, lastBeat, modeError, v, a, l, e);
    end
  endtask

  // called at a negedge; drives the start, checks up to 'limit' beats
  // R11: lenCode 0/1/2 -> 2/4/8 beats, 3 -> page; interleave=1 -> XOR order
  task automatic runBurst(input int s, input int len, input bit ilv, input int limit);
    int n;
    int off;
    int upper;
    int expA;
    startPulse = 1'b1; startCol = CW'(s); lenCode = 2'(len); interleave = ilv;
    @(negedge clk);
    startPulse = 1'b0;
    if (len == 3) begin
      for (int k = 0; k < limit; k++) begin
        chk("R7", 1'b1, (s + k) % PAGE, 1'b0, 1'b0);
        @(negedge clk);
      end
      chk("R7", 1'b1, (s + limit) % PAGE, 1'b0, 1'b0);
      terminate = 1'b1;
      @(negedge clk);
      terminate = 1'b0;
      chk("R8", 1'b0, 0, 1'b0, 1'b0);
    end else begin
      n = 2 << len;
      off = s % n;
      upper = s - off;
      for (int k = 0; k < n && k < limit; k++) begin
        expA = ilv ? upper + (off ^ k) : upper + ((off + k) % n);
        if (k == 0) chk("R2", 1'b1, expA, n == 1, 1'b0);
        else chk(ilv ? "R4" : "R3", 1'b1, expA, k == n - 1, 1'b0);
        @(negedge clk);
      end
      if (limit >= n) chk("R5", 1'b0, 0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 1'b0, 0, 1'b0, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", 1'b0, 0, 1'b0, 1'b0);

    // exhaustive sweep: R3, R4, R5, R6, R7, R8
    for (int s = 0; s < PAGE; s++) begin
      for (int len = 0; len < 4; len++) begin
        for (int ilv = 0; ilv < 2; ilv++) begin
          if (!(len == 3 && ilv == 1)) runBurst(s, len, ilv[0], PAGE + 2);
        end
      end
    end

    // R9: unsupported request during a running burst
    runBurst(5, 2, 1'b0, 3);
    startPulse = 1'b1; startCol = CW'(9); lenCode = 2'd3; interleave = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R9", 1'b0, 0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9", 1'b0, 0, 1'b0, 1'b0);

    // R10: restart mid-burst, fixed and page-length
    runBurst(13, 2, 1'b1, 3);
    runBurst(6, 1, 1'b1, 8);
    runBurst(20, 3, 1'b0, 4);
    runBurst(3, 0, 1'b0, 1);
    runBurst(17, 2, 1'b1, 8);

    // R8: terminate on a fixed burst
    runBurst(10, 2, 1'b0, 2);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    chk("R8", 1'b0, 0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule